// File: doc/BRIEF.md
# Mixed-Width Register Access Adapter

This block lets a bus master issue byte, 16-bit or 32-bit accesses to a register bank whose registers each have a fixed native width. A width map looks up the native width of every 4-byte group from the offset. Whenever the size of an access differs from the native width at its offset, the adapter turns it into a short series of native-width operations. Wide accesses are split into big-endian halves. Narrow reads pick the right part out of a wider register. Narrow writes to wider registers become read-modify-write sequences.

The bank behind the adapter is a simple big-endian byte store with a registered read port, so every native read takes two cycles. The master raises a request for one cycle while the adapter is idle. The adapter then answers with a one-cycle ready pulse, which carries the read data or an error flag. Requests that arrive while a sequence is running are not taken.

Top module: `mw_access_adapter`

## Requirements
- R1: After reset, rsp_ready_o is low and every byte of the store reads as zero.
- R2: Only address bits 9:0 form the offset. Higher address bits are ignored, so the whole 4 KB window aliases onto 1 KB of offsets.
- R3: An access is refused when its size code is 3 or when any byte it covers lies at or above offset 0x200. A refused access gives rsp_ready_o and rsp_err_o high in the first cycle after acceptance, with rsp_rdata_o zero, and leaves the store untouched. rsp_err_o is low on every other response.
- R4: The native width of the group at offset bits 8:2 is set by offset bits 7:6: 00 gives byte registers (map value 1), 01 gives 16-bit (2), 10 gives 32-bit (4), and 11 gives an unimplemented group (0). Unimplemented groups read as zero and ignore writes.
- R5: A byte read from a 16-bit or 32-bit register returns a byte of the aligned halfword that contains it: the upper byte for an even offset, the lower byte for an odd one.
- R6: A 16-bit read from a 32-bit register returns the upper half of the aligned longword when offset bits 1:0 are 00. For any other value of those bits it returns the lower half.
- R7: A 16-bit read in a byte group is done as two byte reads. The byte at the offset becomes bits 15:8 and the byte at offset+1 becomes bits 7:0, and the second byte may lie in the next group.
- R8: A 32-bit access in a group narrower than 32 bits is done as a 16-bit access at the offset, which carries bits 31:16, followed by a 16-bit access at offset+2, which carries bits 15:0. This holds for reads and writes.
- R9: A byte write to a 16-bit or 32-bit register reads that register, replaces only the addressed byte, and writes the register back.
- R10: A 16-bit write to a 32-bit register replaces the half that R6 selects and keeps the other half. A 16-bit write in a byte group is done as two byte writes, the high byte at the offset and the low byte at offset+1.
- R11: An access whose size matches the native width is one native operation. Data is big-endian, with the most significant byte at the lowest offset, and native 16-bit and 32-bit operations use the aligned base address. Read data is right-aligned in rsp_rdata_o with the upper bits zero.
- R12: The sequence time counts every native operation: 2 cycles for a read, 1 cycle for a write of a whole register, and 2 cycles for a read-modify-write. rsp_ready_o goes high for exactly one cycle, which follows the last native operation. Write responses carry zero data.
- R13: A request raised while a sequence is in progress, up to and including the ready cycle, is ignored and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken only while the adapter is idle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | Size code: 0 = byte, 1 = 16-bit, 2 = 32-bit, 3 = invalid |
| req_addr_i | input | ADDR_W | Byte address; bits 9:0 form the offset |
| req_wdata_i | input | 32 | Write data, right-aligned |
| rsp_ready_o | output | 1 | One-cycle pulse that ends a request |
| rsp_err_o | output | 1 | Request refused (valid with rsp_ready_o) |
| rsp_rdata_o | output | 32 | Read data, right-aligned (valid with rsp_ready_o) |

## Verification
If the sequence plan holds a wrong entry, the ready pulse comes early or late. A wrong merge or lane choice shows up as wrong data on the very access that goes through that path, or on the first later read of the bytes it corrupted. The bench therefore predicts the exact ready cycle of every access and compares it on every clock. It also reads back what each write left behind, with accesses of every size, at group boundaries, at odd offsets and at aliased addresses. A write that leaks into a neighbouring byte shows up only on a later read, and the mixed-size random traffic reaches those reads within a few accesses.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int SUB_W  = 9;              // in-range offset bits
  localparam int LIMIT  = 1 << SUB_W;     // first refused offset
  localparam int GRP_W  = SUB_W - 2;
  localparam int NSLOT  = 4;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_LONG = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_DATA, ST_RESP} seq_state_e;

  // one native operation of a sequence
  typedef struct packed {
    logic             vld;
    logic [SUB_W-1:0] base;  // aligned native address
    logic [2:0]       nw;    // native width in bytes, 0 = unimplemented
    logic [1:0]       po;    // first byte of the piece inside the register
    logic [2:0]       psz;   // piece size in bytes
    logic [1:0]       lane;  // first request byte the piece maps to
  } leaf_t;

  function automatic logic [2:0] grp_width(logic [GRP_W-1:0] g);
    case (g[5:4])
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      2'b10:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [2:0] size_bytes(logic [1:0] code);
    case (code)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      SZ_LONG: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic leaf_t byte_leaf(logic [SUB_W-1:0] b, logic [1:0] lane);
    leaf_t l;
    l.vld  = 1'b1;
    l.nw   = grp_width(b[SUB_W-1:2]);
    l.psz  = 3'd1;
    l.lane = lane;
    case (l.nw)
      3'd4: begin l.base = {b[SUB_W-1:2], 2'b00}; l.po = b[1:0]; end
      3'd2: begin l.base = {b[SUB_W-1:1], 1'b0}; l.po = {1'b0, b[0]}; end
      default: begin l.base = b; l.po = 2'd0; end
    endcase
    return l;
  endfunction

  // byte i (0 = most significant) of a right-aligned nw-byte value
  function automatic logic [7:0] nat_byte(logic [31:0] d, logic [2:0] nw, int i);
    if (i < int'(nw)) return d[(int'(nw) - 1 - i) * 8 +: 8];
    return 8'h00;
  endfunction
endpackage

// File: rtl/mw_leaf_planner.sv
module mw_leaf_planner
  import mw_pkg::*;
(
  input  logic [1:0]             size_i,
  input  logic [SUB_W-1:0]       off_i,
  output leaf_t [NSLOT-1:0]      leaves_o
);
  logic [SUB_W-1:0] h;
  logic [2:0]       hw;

  always_comb begin
    leaves_o = '0;
    h  = '0;
    hw = '0;
    if (size_i == SZ_BYTE) begin
      leaves_o[0] = byte_leaf(off_i, 2'd0);
    end else if (size_i == SZ_LONG && grp_width(off_i[SUB_W-1:2]) == 3'd4) begin
      leaves_o[0].vld  = 1'b1;
      leaves_o[0].base = {off_i[SUB_W-1:2], 2'b00};
      leaves_o[0].nw   = 3'd4;
      leaves_o[0].po   = 2'd0;
      leaves_o[0].psz  = 3'd4;
      leaves_o[0].lane = 2'd0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (i == 0 || size_i == SZ_LONG) begin
          h  = off_i + SUB_W'(2 * i);
          hw = grp_width(h[SUB_W-1:2]);
          if (hw == 3'd4) begin
            leaves_o[2*i].vld  = 1'b1;
            leaves_o[2*i].base = {h[SUB_W-1:2], 2'b00};
            leaves_o[2*i].nw   = 3'd4;
            leaves_o[2*i].po   = (h[1:0] == 2'b00) ? 2'd0 : 2'd2;
            leaves_o[2*i].psz  = 3'd2;
            leaves_o[2*i].lane = 2'(2 * i);
          end else if (hw == 3'd2) begin
            leaves_o[2*i].vld  = 1'b1;
            leaves_o[2*i].base = {h[SUB_W-1:1], 1'b0};
            leaves_o[2*i].nw   = 3'd2;
            leaves_o[2*i].po   = 2'd0;
            leaves_o[2*i].psz  = 3'd2;
            leaves_o[2*i].lane = 2'(2 * i);
          end else begin
            leaves_o[2*i]   = byte_leaf(h, 2'(2 * i));
            leaves_o[2*i+1] = byte_leaf(h + SUB_W'(1), 2'(2 * i + 1));
          end
        end
      end
    end
  end
endmodule

// File: rtl/mw_reg_store.sv
module mw_reg_store #(
  parameter int BYTES = 512
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [$clog2(BYTES)-1:0] addr_i,
  input  logic [2:0]               nw_i,
  input  logic [31:0]              wdata_i,
  output logic [31:0]              rdata_o
);
  localparam int AW = $clog2(BYTES);

  logic [7:0]  mem [BYTES];
  logic [31:0] rd_next;

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < 4; i++)
      if (i < int'(nw_i)) rd_next = {rd_next[23:0], mem[addr_i + AW'(i)]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BYTES; i++) mem[i] <= '0;
      rdata_o <= '0;
    end else begin
      if (we_i)
        for (int i = 0; i < 4; i++)
          if (i < int'(nw_i))
            mem[addr_i + AW'(i)] <= wdata_i[(int'(nw_i) - 1 - i) * 8 +: 8];
      rdata_o <= rd_next;
    end
  end
endmodule

// File: rtl/mw_access_adapter.sv
module mw_access_adapter
  import mw_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [1:0]        req_size_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_ready_o,
  output logic              rsp_err_o,
  output logic [31:0]       rsp_rdata_o
);
  localparam int OFF_W = SUB_W + 1;

  seq_state_e         st_q;
  logic               wr_q, err_q;
  logic [1:0]         size_q;
  logic [SUB_W-1:0]   off_q;
  logic [31:0]        wdata_q;
  logic [1:0]         slot_q;
  logic [3:0][7:0]    acc_q;

  logic [OFF_W-1:0]   off_in;
  logic [2:0]         szb_in, szb_q;
  logic [OFF_W:0]     last_in;
  logic               bad_in;

  leaf_t [NSLOT-1:0]  leaves;
  leaf_t              cur;
  logic               partial, has_next;
  logic [1:0]         next_slot;
  logic [3:0][7:0]    pc;
  logic [31:0]        piece_word, merged;
  logic               st_we;
  logic [31:0]        st_wdata, st_rdata;
  logic               busy;
  logic               unused_addr;

  assign unused_addr = ^req_addr_i[ADDR_W-1:OFF_W];
  assign busy        = (st_q != ST_IDLE);

  // refusal check at acceptance
  always_comb begin
    off_in  = req_addr_i[OFF_W-1:0];
    szb_in  = size_bytes(req_size_i);
    last_in = {1'b0, off_in} + (OFF_W+1)'(szb_in) - (OFF_W+1)'(1);
    bad_in  = (szb_in == 3'd0) || (last_in >= (OFF_W+1)'(LIMIT));
  end

  mw_leaf_planner u_plan (
    .size_i  (size_q),
    .off_i   (off_q),
    .leaves_o(leaves)
  );

  assign szb_q   = size_bytes(size_q);
  assign cur     = leaves[slot_q];
  assign partial = (cur.psz < cur.nw);

  always_comb begin
    has_next  = 1'b0;
    next_slot = slot_q;
    for (int s = NSLOT - 1; s >= 0; s--)
      if (s > int'(slot_q) && leaves[s].vld) begin
        has_next  = 1'b1;
        next_slot = 2'(s);
      end
  end

  // piece bytes taken from the right-aligned request data
  always_comb begin
    pc         = '0;
    piece_word = '0;
    for (int j = 0; j < 4; j++) begin
      if (j < int'(cur.psz) && (int'(cur.lane) + j) < int'(szb_q))
        pc[j] = wdata_q[(int'(szb_q) - 1 - int'(cur.lane) - j) * 8 +: 8];
      if (j < int'(cur.psz)) piece_word = {piece_word[23:0], pc[j]};
    end
  end

  always_comb begin
    logic [7:0] b;
    merged = '0;
    for (int i = 0; i < 4; i++) begin
      if (i >= int'(cur.po) && i < int'(cur.po) + int'(cur.psz))
        b = pc[i - int'(cur.po)];
      else
        b = nat_byte(st_rdata, cur.nw, i);
      if (i < int'(cur.nw)) merged = {merged[23:0], b};
    end
  end

  assign st_we    = wr_q && ((st_q == ST_ISSUE && !partial) || st_q == ST_DATA);
  assign st_wdata = (st_q == ST_DATA) ? merged : piece_word;

  mw_reg_store #(.BYTES(LIMIT)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (st_we),
    .addr_i (cur.base),
    .nw_i   (cur.nw),
    .wdata_i(st_wdata),
    .rdata_o(st_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      wr_q    <= 1'b0;
      err_q   <= 1'b0;
      size_q  <= SZ_BYTE;
      off_q   <= '0;
      wdata_q <= '0;
      slot_q  <= '0;
      acc_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid_i) begin
          wr_q    <= req_write_i;
          size_q  <= req_size_i;
          off_q   <= off_in[SUB_W-1:0];
          wdata_q <= req_wdata_i;
          err_q   <= bad_in;
          slot_q  <= '0;
          acc_q   <= '0;
          st_q    <= bad_in ? ST_RESP : ST_ISSUE;
        end
        ST_ISSUE: begin
          if (wr_q && !partial) begin
            slot_q <= next_slot;
            st_q   <= has_next ? ST_ISSUE : ST_RESP;
          end else begin
            st_q <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (!wr_q)
            for (int j = 0; j < 4; j++)
              if (j < int'(cur.psz) && (int'(cur.lane) + j) < 4)
                acc_q[int'(cur.lane) + j] <= nat_byte(st_rdata, cur.nw, int'(cur.po) + j);
          slot_q <= next_slot;
          st_q   <= has_next ? ST_ISSUE : ST_RESP;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_ready_o = (st_q == ST_RESP);
  assign rsp_err_o   = rsp_ready_o && err_q;

  always_comb begin
    rsp_rdata_o = '0;
    for (int l = 0; l < 4; l++)
      if (l < int'(szb_q)) rsp_rdata_o[(int'(szb_q) - 1 - l) * 8 +: 8] = acc_q[l];
  end
endmodule

// File: rtl/mw_access_adapter_chk.sv
module mw_access_adapter_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              rsp_ready_o,
  input logic              rsp_err_o,
  input logic [31:0]       rsp_rdata_o,
  input logic              busy,
  input logic              st_we
);
  AST_READY_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_ready_o |=> !rsp_ready_o); // R12
  AST_ERR_WITH_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> rsp_ready_o); // R3
  AST_ERR_ZERO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_ready_o && rsp_err_o) |-> (rsp_rdata_o == 32'd0)); // R3
  AST_ERR_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && req_valid_i && req_addr_i[9]) |=> (rsp_ready_o && rsp_err_o)); // R3
  AST_IDLE_AFTER_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_ready_o |=> !busy); // R13
  AST_NO_STORE_WRITE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !st_we); // R13
  AST_NO_WRITE_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && req_valid_i && req_addr_i[9]) |=> !st_we); // R3
endmodule

bind mw_access_adapter mw_access_adapter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_addr_i (req_addr_i),
  .rsp_ready_o(rsp_ready_o),
  .rsp_err_o  (rsp_err_o),
  .rsp_rdata_o(rsp_rdata_o),
  .busy       (busy),
  .st_we      (st_we)
);

// File: tb/sim_mw_access_adapter.sv
module sim_mw_access_adapter;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 12;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_write_i = 1'b0;
  logic [1:0]        req_size_i = '0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [31:0]       req_wdata_i = '0;
  logic              rsp_ready_o, rsp_err_o;
  logic [31:0]       rsp_rdata_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mw_access_adapter #(.ADDR_W(ADDR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .req_size_i(req_size_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rsp_ready_o(rsp_ready_o), .rsp_err_o(rsp_err_o), .rsp_rdata_o(rsp_rdata_o)
  );

  // behavioural model: byte image plus recursive width conversion
  bit [7:0] m_mem [512];
  int       m_cost;

  function automatic int wm(int o);
    case ((o >> 6) & 3)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic int nat_rd(int b, int n);
    int v = 0;
    m_cost += 2;
    for (int i = 0; i < n; i++) v = (v << 8) | int'(m_mem[(b + i) & 511]);
    return v;
  endfunction

  function automatic int m_rdl(int o);
    if (wm(o) < 4) return (m_rdw(o) << 16) | m_rdw(o + 2);
    return nat_rd(o & ~3, 4);
  endfunction

  function automatic int m_rdw(int o);
    int n = wm(o);
    int v;
    if (n == 4) begin
      v = m_rdl(o & ~3);
      return ((o & 3) == 0) ? ((v >> 16) & 'hffff) : (v & 'hffff);
    end
    if (n == 2) return nat_rd(o & ~1, 2);
    return (m_rdb(o) << 8) | m_rdb(o + 1);
  endfunction

  function automatic int m_rdb(int o);
    int n = wm(o);
    int v;
    if (n > 1) begin
      v = m_rdw(o & ~1);
      return ((o & 1) != 0) ? (v & 'hff) : ((v >> 8) & 'hff);
    end
    return nat_rd(o, n);
  endfunction

  function automatic void m_wrb(int o, int v);
    int n = wm(o);
    m_cost += (n > 1) ? 2 : 1;
    if (n != 0) m_mem[o & 511] = 8'(v);
  endfunction

  function automatic void m_wrw(int o, int v);
    int n = wm(o);
    int p;
    if (n == 4) begin
      m_cost += 2;
      p = ((o & 3) == 0) ? (o & ~3) : ((o & ~3) + 2);
      m_mem[p & 511] = 8'(v >> 8);
      m_mem[(p + 1) & 511] = 8'(v);
    end else if (n == 2) begin
      m_cost += 1;
      m_mem[(o & ~1) & 511] = 8'(v >> 8);
      m_mem[((o & ~1) + 1) & 511] = 8'(v);
    end else begin
      m_wrb(o, v >> 8);
      m_wrb(o + 1, v & 'hff);
    end
  endfunction

  function automatic void m_wrl(int o, int v);
    if (wm(o) < 4) begin
      m_wrw(o, (v >> 16) & 'hffff);
      m_wrw(o + 2, v & 'hffff);
    end else begin
      m_cost += 1;
      for (int i = 0; i < 4; i++) m_mem[((o & ~3) + i) & 511] = 8'(v >> (24 - 8 * i));
    end
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one access; compares ready on every cycle, then error and data
  task automatic access(bit wr, int szc, int addr, int wd, string tag,
                        bit use_exp = 0, int exp_v = 0, bit inject = 0);
    int  off  = addr & 'h3ff;
    int  szb  = (szc == 0) ? 1 : (szc == 1) ? 2 : (szc == 2) ? 4 : 0;
    bit  bad  = (szb == 0) || (off + szb - 1 >= 'h200);
    int  ev   = 0;
    int  cost;
    bit  seen = 0;
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = wr; req_size_i = 2'(szc);
    req_addr_i = ADDR_W'(addr); req_wdata_i = wd;
    m_cost = 0;
    if (!bad) begin
      if (wr) begin
        if (szb == 1) m_wrb(off, wd & 'hff);
        else if (szb == 2) m_wrw(off, wd & 'hffff);
        else m_wrl(off, wd);
      end else begin
        if (szb == 1) ev = m_rdb(off);
        else if (szb == 2) ev = m_rdw(off);
        else ev = m_rdl(off);
      end
    end
    cost = m_cost;
    for (int k = 1; k <= cost + 1 && !seen; k++) begin
      @(negedge clk);
      if (k == 1) req_valid_i = 1'b0;
      if (inject && k == 1) begin  // R13 stray request while busy
        req_valid_i = 1'b1; req_write_i = 1'b1; req_size_i = 2'd2;
        req_addr_i = 'h080; req_wdata_i = 32'hDEAD_BEEF;
      end
      if (inject && k == cost) req_valid_i = 1'b0;
      check("R12", "ready timing", 32'(rsp_ready_o), 32'(k == cost + 1));
      if (k == cost + 1) begin
        seen = 1;
        check("R3", "error flag", 32'(rsp_err_o), 32'(bad));
        check(tag, "response data", rsp_rdata_o, 32'(ev));
        if (use_exp) check(tag, "expected constant", rsp_rdata_o, 32'(exp_v));
      end
    end
    req_valid_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    check("R1", "ready in reset", 32'(rsp_ready_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", "ready after reset", 32'(rsp_ready_o), 32'd0);
    access(0, 2, 'h080, 0, "R1", 1, 0);
    access(0, 1, 'h040, 0, "R1", 1, 0);

    access(1, 2, 'h080, 'h11223344, "R11");
    access(0, 2, 'h080, 0, "R11", 1, 'h11223344);
    access(0, 0, 'h080, 0, "R5", 1, 'h11);
    access(0, 0, 'h083, 0, "R5", 1, 'h44);
    access(0, 1, 'h080, 0, "R6", 1, 'h1122);
    access(0, 1, 'h082, 0, "R6", 1, 'h3344);
    access(0, 1, 'h081, 0, "R6", 1, 'h3344);

    access(1, 0, 'h000, 'hA1, "R11");
    access(1, 0, 'h001, 'hB2, "R11");
    access(1, 0, 'h03F, 'hC3, "R11");
    access(1, 1, 'h040, 'hD4E5, "R11");
    access(0, 1, 'h041, 0, "R11", 1, 'hD4E5);
    access(0, 1, 'h000, 0, "R7", 1, 'hA1B2);
    access(0, 1, 'h03F, 0, "R7", 1, 'hC3D4);
    access(0, 0, 'h041, 0, "R5", 1, 'hE5);

    access(1, 2, 'h004, 'h01020304, "R8");
    access(0, 0, 'h006, 0, "R8", 1, 'h03);
    access(0, 2, 'h004, 0, "R8", 1, 'h01020304);
    access(0, 2, 'h040, 0, "R8", 1, 'hD4E50000);

    access(1, 0, 'h041, 'h77, "R9");
    access(0, 1, 'h040, 0, "R9", 1, 'hD477);
    access(1, 0, 'h082, 'h99, "R9");
    access(0, 2, 'h080, 0, "R9", 1, 'h11229944);

    access(1, 1, 'h086, 'hBEEF, "R10");
    access(0, 2, 'h084, 0, "R10", 1, 'h0000BEEF);
    access(1, 1, 'h080, 'hCAFE, "R10");
    access(0, 2, 'h080, 0, "R10", 1, 'hCAFE9944);
    access(1, 1, 'h010, 'h5566, "R10");
    access(0, 0, 'h011, 0, "R10", 1, 'h66);

    access(1, 2, 'h0C0, 'hFFFFFFFF, "R4");
    access(0, 2, 'h0C0, 0, "R4", 1, 0);
    access(0, 0, 'h1C3, 0, "R4", 1, 0);

    access(0, 2, 'hC80, 0, "R2", 1, 'hCAFE9944);
    access(0, 1, 'h482, 0, "R2", 1, 'h9944);

    access(0, 2, 'h200, 0, "R3", 1, 0);
    access(1, 2, 'h1FE, 'h12345678, "R3");
    access(1, 0, 'h3FF, 'h12, "R3");
    access(0, 3, 'h080, 0, "R3", 1, 0);
    access(0, 1, 'h1FE, 0, "R3", 1, 0);

    access(0, 2, 'h000, 0, "R13", 1, 'hA1B20000, 1);
    access(0, 2, 'h080, 0, "R13", 1, 'hCAFE9944);

    for (int n = 0; n < 500; n++) begin
      int a  = int'($urandom_range(0, 511));
      int hi = int'($urandom_range(0, 7));
      int sz = int'($urandom_range(0, 8) == 0 ? 3 : $urandom_range(0, 2));
      access(bit'($urandom_range(0, 1)), sz, a | (hi << 9), int'($urandom), "R11");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule